// File: doc/BRIEF.md
# Signed Index Range Checker

This unit decides whether a signed array index lies inside a pair of limits kept in memory. A request carries the index, the byte address of the limit pair and a width select of 16 or 32 bits. The unit reads the lower limit at the base address, then the upper limit one element further on. It then compares the index with both limits and returns a one-cycle completion pulse with a 2-bit outcome code.

The upper test is inclusive of the element size. An index may exceed the stored upper limit by as much as the operand size in bytes (2 or 4) and still pass. A request whose second operand is flagged as not residing in memory ends at once with an illegal-operation code, and no read is issued. A fault outcome comes with a restart flag, which tells the pipeline to resume at the checking instruction itself and to commit nothing. A pass comes with a commit flag instead.

Top module: `idxchk_unit`

## Requirements
- R1: After reset, `done`, `mem_req`, `restart_here` and `commit_ok` are 0, `status` is 0 and `req_ready` is 1.
- R2: A memory-operand request makes exactly two reads. The first is at `req_base` and returns the lower limit. The second is at `req_base`+4 when `req_wide`=1 or `req_base`+2 when `req_wide`=0, and returns the upper limit.
- R3: An index below the lower limit, compared as signed values, gives `status`=1 (range fault).
- R4: An index equal to the upper limit plus the size in bytes (4 wide, 2 narrow) gives `status`=0. An index one above that gives `status`=1.
- R5: With `req_wide`=0, only bits 15:0 of the index and of each read word are used, each sign-extended. Bits 31:16 have no effect on the outcome.
- R6: The sum of the upper limit and the size is formed without wrap-around. An index of 0x7FFFFFFF against an upper limit of 0x7FFFFFFF (wide), or 0x7FFF against 0x7FFF (narrow), passes.
- R7: While `mem_req` is high and `mem_ack` is low, `mem_req` stays high and `mem_addr` stays unchanged. Read data is taken in the cycle `mem_ack` is high, whatever the wait length.
- R8: A request with `req_not_mem`=1 completes with `status`=2 in the cycle after acceptance and makes no read.
- R9: `done` is high for exactly one cycle per accepted request. `status` is one of 0 (pass), 1 (range fault) or 2 (illegal operand) while `done` is high.
- R10: With `done` high, `restart_here` is 1 and `commit_ok` is 0 for status 1 or 2. `commit_ok` is 1 and `restart_here` is 0 for status 0.
- R11: `req_ready` is high only while idle. A `req_valid` pulse during a check is ignored: it produces no extra completion and leaves the running outcome unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a check (taken only while idle) |
| req_index | input | 32 | Signed index to check |
| req_base | input | 32 | Byte address of the limit pair |
| req_wide | input | 1 | 1 = 32-bit operands, 0 = 16-bit operands |
| req_not_mem | input | 1 | Second operand is not a memory location |
| req_ready | output | 1 | Unit is idle and accepts a request |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | 32 | Byte address of the read |
| mem_ack | input | 1 | Read acknowledge; data valid this cycle |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 pass, 1 range fault, 2 illegal operand |
| restart_here | output | 1 | Fault: resume at the checking instruction, nothing committed |
| commit_ok | output | 1 | Pass: result may be committed |

## Verification
The no-wrap case at the top of the signed range matters because a truncated sum would turn a legal index into a false fault. The stimulus places the largest positive index against the largest positive upper limit in both widths. Ignoring a request while busy is also hard to see at the ports, so a request is pulsed into the middle of a slow, multi-wait-state read and the test counts the completion pulses and checks the outcome. Narrow mode is driven with garbage in the upper halves of the index and the read words, so any leak of those bits into the comparison changes the outcome.

// File: rtl/idxchk_pkg.sv
package idxchk_pkg;
  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_GET_LO  = 3'd1,
    S_GET_HI  = 3'd2,
    S_JUDGE   = 3'd3,
    S_FINISH  = 3'd4
  } chk_state_t;

  typedef enum logic [1:0] {
    RES_PASS  = 2'd0,
    RES_RANGE = 2'd1,
    RES_BADOP = 2'd2
  } chk_result_t;
endpackage

// File: rtl/idxchk_cmp.sv
module idxchk_cmp #(
  parameter int DW = 32,
  parameter int NW = 16
) (
  input  logic [DW-1:0] idx,
  input  logic [DW-1:0] lo_raw,
  input  logic [DW-1:0] hi_raw,
  input  logic          wide,
  output logic          below,
  output logic          above
);
  localparam int XW = DW + 2;
  localparam int WIDE_BYTES = DW / 8;
  localparam int NARROW_BYTES = NW / 8;

  logic signed [XW-1:0] idx_x, lo_x, hi_x, hi_lim;

  always_comb begin
    if (wide) begin
      idx_x = {{(XW-DW){idx[DW-1]}}, idx};
      lo_x  = {{(XW-DW){lo_raw[DW-1]}}, lo_raw};
      hi_x  = {{(XW-DW){hi_raw[DW-1]}}, hi_raw};
      hi_lim = hi_x + XW'(WIDE_BYTES);
    end else begin
      idx_x = {{(XW-NW){idx[NW-1]}}, idx[NW-1:0]};
      lo_x  = {{(XW-NW){lo_raw[NW-1]}}, lo_raw[NW-1:0]};
      hi_x  = {{(XW-NW){hi_raw[NW-1]}}, hi_raw[NW-1:0]};
      hi_lim = hi_x + XW'(NARROW_BYTES);
    end
    below = idx_x < lo_x;
    above = idx_x > hi_lim;
  end
endmodule

// File: rtl/idxchk_seq.sv
module idxchk_seq
  import idxchk_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [DW-1:0] req_index,
  input  logic [AW-1:0] req_base,
  input  logic          req_wide,
  input  logic          req_not_mem,
  output logic          req_ready,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] cmp_idx,
  output logic [DW-1:0] cmp_lo,
  output logic [DW-1:0] cmp_hi,
  output logic          cmp_wide,
  input  logic          cmp_below,
  input  logic          cmp_above,
  output logic          done,
  output logic [1:0]    status,
  output logic          restart_here,
  output logic          commit_ok
);
  localparam logic [AW-1:0] STEP_WIDE   = AW'(DW / 8);
  localparam logic [AW-1:0] STEP_NARROW = AW'(NW / 8);

  chk_state_t    state;
  logic [AW-1:0] base_q;
  logic          fault;

  assign req_ready = (state == S_IDLE);
  assign fault     = cmp_below | cmp_above;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      base_q       <= '0;
      cmp_idx      <= '0;
      cmp_lo       <= '0;
      cmp_hi       <= '0;
      cmp_wide     <= 1'b0;
      mem_req      <= 1'b0;
      mem_addr     <= '0;
      done         <= 1'b0;
      status       <= RES_PASS;
      restart_here <= 1'b0;
      commit_ok    <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            cmp_idx  <= req_index;
            cmp_wide <= req_wide;
            base_q   <= req_base;
            if (req_not_mem) begin
              status       <= RES_BADOP;
              done         <= 1'b1;
              restart_here <= 1'b1;
              commit_ok    <= 1'b0;
              state        <= S_FINISH;
            end else begin
              mem_req  <= 1'b1;
              mem_addr <= req_base;
              state    <= S_GET_LO;
            end
          end
        end
        S_GET_LO: begin
          if (mem_ack) begin
            cmp_lo   <= mem_rdata;
            mem_addr <= base_q + (cmp_wide ? STEP_WIDE : STEP_NARROW);
            state    <= S_GET_HI;
          end
        end
        S_GET_HI: begin
          if (mem_ack) begin
            cmp_hi  <= mem_rdata;
            mem_req <= 1'b0;
            state   <= S_JUDGE;
          end
        end
        S_JUDGE: begin
          status       <= fault ? RES_RANGE : RES_PASS;
          done         <= 1'b1;
          restart_here <= fault;
          commit_ok    <= ~fault;
          state        <= S_FINISH;
        end
        S_FINISH: begin
          done         <= 1'b0;
          restart_here <= 1'b0;
          commit_ok    <= 1'b0;
          state        <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7: request and address are held while waiting
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R9: completion is a single-cycle pulse
  p_done_once_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: only defined outcome codes appear with done
  p_code_legal_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (status != 2'd3));

  // R10: exactly one of restart and commit accompanies completion
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (restart_here != commit_ok));

  // R8: a non-memory operand finishes next cycle without reading
  p_nomem_r8: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid && req_not_mem) |=> (done && !mem_req && status == RES_BADOP));

  // R11: no read is outstanding while idle
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req);
endmodule

// File: rtl/idxchk_unit.sv
module idxchk_unit #(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [DW-1:0] req_index,
  input  logic [AW-1:0] req_base,
  input  logic          req_wide,
  input  logic          req_not_mem,
  output logic          req_ready,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic [1:0]    status,
  output logic          restart_here,
  output logic          commit_ok
);
  logic [DW-1:0] c_idx, c_lo, c_hi;
  logic          c_wide, c_below, c_above;

  idxchk_seq #(.DW(DW), .AW(AW), .NW(NW)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_index(req_index), .req_base(req_base),
    .req_wide(req_wide), .req_not_mem(req_not_mem), .req_ready(req_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cmp_idx(c_idx), .cmp_lo(c_lo), .cmp_hi(c_hi), .cmp_wide(c_wide),
    .cmp_below(c_below), .cmp_above(c_above),
    .done(done), .status(status), .restart_here(restart_here), .commit_ok(commit_ok)
  );

  idxchk_cmp #(.DW(DW), .NW(NW)) u_cmp (
    .idx(c_idx), .lo_raw(c_lo), .hi_raw(c_hi), .wide(c_wide),
    .below(c_below), .above(c_above)
  );
endmodule

// File: tb/idxchk_unit_bench.sv
module idxchk_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_index = '0;
  logic [31:0] req_base = '0;
  logic        req_wide = 1'b0;
  logic        req_not_mem = 1'b0;
  logic        req_ready;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done;
  logic [1:0]  status;
  logic        restart_here;
  logic        commit_ok;

  always #5 clk = ~clk;

  idxchk_unit u_idxchk_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_index(req_index),
    .req_base(req_base), .req_wide(req_wide), .req_not_mem(req_not_mem),
    .req_ready(req_ready), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .status(status),
    .restart_here(restart_here), .commit_ok(commit_ok)
  );

  int checks = 0;
  int fails = 0;
  int lat = 0;
  int wcnt = 0;
  int reads = 0;
  int addr_errs = 0;
  int dones = 0;
  logic [31:0] cur_lo = '0, cur_hi = '0, cur_base = '0;
  logic        cur_wide = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] answer(input logic [31:0] a);
    if (a == cur_base) return cur_lo;
    if (a == cur_base + (cur_wide ? 32'd4 : 32'd2)) return cur_hi;
    return 32'hBAD0_BAD0;
  endfunction

  // memory model: acknowledge after lat wait cycles
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      if (wcnt >= lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= answer(mem_addr);
        reads     <= reads + 1;
        if (answer(mem_addr) == 32'hBAD0_BAD0) addr_errs <= addr_errs + 1;
        wcnt      <= 0;
      end else begin
        wcnt <= wcnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  always @(posedge clk) if (done) dones <= dones + 1;

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // {wide, not_mem, index, lo, hi, expected status}
  localparam int NV = 13;
  localparam logic [99:0] VT [NV] = '{
    {1'b1, 1'b0, 32'h0000_0005, 32'h0000_0000, 32'h0000_000A, 2'd0}, // R3/R4 inside
    {1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_000A, 2'd1}, // R3 below
    {1'b1, 1'b0, 32'hFFFF_FFF9, 32'hFFFF_FFF9, 32'h0000_000A, 2'd0}, // R3 equal lower
    {1'b1, 1'b0, 32'h0000_000E, 32'h0000_0000, 32'h0000_000A, 2'd0}, // R4 hi+4
    {1'b1, 1'b0, 32'h0000_000F, 32'h0000_0000, 32'h0000_000A, 2'd1}, // R4 hi+5
    {1'b1, 1'b0, 32'h7FFF_FFFF, 32'h0000_0000, 32'h7FFF_FFFF, 2'd0}, // R6 wide
    {1'b0, 1'b0, 32'h0000_0010, 32'h0000_0000, 32'h0000_000E, 2'd0}, // R4 narrow hi+2
    {1'b0, 1'b0, 32'h0000_0011, 32'h0000_0000, 32'h0000_000E, 2'd1}, // R4 narrow hi+3
    {1'b0, 1'b0, 32'hABCD_FFFE, 32'h1234_FFFE, 32'hFFFF_0003, 2'd0}, // R5 upper bits ignored
    {1'b0, 1'b0, 32'h0000_7FFF, 32'h0000_8000, 32'h0000_7FFF, 2'd0}, // R6 narrow
    {1'b0, 1'b0, 32'h0000_0008, 32'h0000_0000, 32'h0000_0005, 2'd1}, // R4 narrow above
    {1'b1, 1'b1, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 2'd2}, // R8
    {1'b0, 1'b0, 32'h0001_0000, 32'hFFFF_0001, 32'h0000_0010, 2'd1}  // R5 low half below
  };

  task automatic start(input logic w, input logic nm, input logic [31:0] idx,
                       input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] base);
    cur_lo = lo; cur_hi = hi; cur_base = base; cur_wide = w;
    req_wide = w; req_not_mem = nm; req_index = idx; req_base = base;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_check(input logic [1:0] exp, input logic nm, input int r0, input int e0, input int d0);
    while (!done) @(negedge clk);
    chk(status == exp, "R3/R4/R5/R6/R8 status", 32'(status), 32'(exp));
    chk(restart_here == (exp != 2'd0), "R10 restart", 32'(restart_here), 32'(exp != 2'd0));
    chk(commit_ok == (exp == 2'd0), "R10 commit", 32'(commit_ok), 32'(exp == 2'd0));
    chk((reads - r0) == (nm ? 0 : 2), "R2/R8 read count", 32'(reads - r0), nm ? 32'd0 : 32'd2);
    chk(addr_errs == e0, "R2 addresses", 32'(addr_errs - e0), 32'd0);
    @(negedge clk);
    chk(!done, "R9 pulse width", 32'(done), 32'd0);
    chk((dones - d0) == 1, "R9/R11 one completion", 32'(dones - d0), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !mem_req && !restart_here && !commit_ok, "R1 outputs idle",
        {28'd0, done, mem_req, restart_here, commit_ok}, 32'd0);
    chk(status == 2'd0, "R1 status", 32'(status), 32'd0);
    chk(req_ready, "R1 ready", 32'(req_ready), 32'd1);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      automatic logic [99:0] v = VT[i];
      automatic int r0 = reads, e0 = addr_errs, d0 = dones;
      lat = i % 3;  // R7 varied wait states
      start(v[99], v[98], v[97:66], v[65:34], v[33:2], 32'h100 + 32'(i * 16));
      finish_check(v[1:0], v[98], r0, e0, d0);
    end

    // R11: request pulsed mid-check is ignored; R7 long waits
    begin
      automatic int r0 = reads, e0 = addr_errs, d0 = dones;
      lat = 4;
      start(1'b1, 1'b0, 32'hFFFF_FF00, 32'h0000_0000, 32'h0000_0040, 32'h0000_0800);
      @(negedge clk);
      chk(!req_ready, "R11 busy not ready", 32'(req_ready), 32'd0);
      req_not_mem = 1'b1; req_index = 32'd1; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; req_not_mem = 1'b0;
      finish_check(2'd1, 1'b0, r0, e0, d0);
      repeat (3) @(negedge clk);
      chk(dones == d0 + 1, "R11 no extra completion", 32'(dones - d0), 32'd1);
    end

    // R7 long wait, pass case
    begin
      automatic int r0 = reads, e0 = addr_errs, d0 = dones;
      lat = 7;
      start(1'b0, 1'b0, 32'h0000_FFFC, 32'h0000_FFF0, 32'h0000_FFFA, 32'h0000_0A02);
      finish_check(2'd0, 1'b0, r0, e0, d0);
    end

    // R1 reset again returns to idle
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(req_ready && status == 2'd0, "R1 after reset", {30'd0, req_ready, |status}, 32'd2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule